// File: doc/BRIEF.md
# Page-Bounded Serial DMA Controller

This block moves data for one serial channel between memory and the line logic. It has a transmit direction that reads words from memory for a sink, and a receive direction that writes words from a source into memory. Software programs each direction with a pointer register and starts work by writing the control register. A transfer always stops at the end of the 4 KiB page that holds the pointer. It never runs for a programmed byte count. Progress is reported through two status events: transmit reached the end of its page, and receive crossed the middle of a page.

Pointer registers hold a 34-bit physical address in rotated form. The top five address bits go in the low five register bits, and address bits 28:2 sit above them. On the memory side the block issues one 32-bit word per valid/ready handshake and tags each word with its direction. The receive source can finish a transfer early by raising a last flag with a word. A static strap identifies the board variant in the status readback. A single interrupt output combines the stored status bits with a mask register.

Register slots are 16 bytes apart. The slot offsets are: control 0x00, transmit pointer 0x10, receive pointer 0x20, status 0x30, mask 0x40. Any other aligned address, including the free-running counter slot at 0x50, reads zero and ignores writes.

Top module: `sdma_page_ctrl`

## Requirements
- R1: A register access whose address has any of bits 3:0 set is misaligned. Writing to it changes no register, and reading it returns zero.
- R2: The memory address of the first word of a transfer is the decoded pointer {reg[4:0], reg[31:5], 2'b00}. Writing a pointer register and reading it back returns the value written.
- R3: A transmit transfer moves (0x1000 - (offset & 0xFFC)) / 4 words at consecutive addresses and never crosses a page. Words are tagged mem_is_rx = 0. While mem_ready is low, the request holds its address and direction.
- R4: Writing control with the transmit enable (bit 0) set while the transmit pointer's page offset (address bits 11:0) is zero starts no transfer. In that case no status bit is set and the enable bit stays set.
- R5: When a transmit page completes, status bit 0 is set and control bit 0 is cleared. The transmit pointer then reads back as the encoded start address of the next page, wrapping at 34 bits.
- R6: Every write to the control register clears status bit 0.
- R7: A receive transfer started by control bit 1 runs to the page end, or until a word arrives with mem_last high. Control bit 1 stays set afterwards, and the receive pointer advances by the number of bytes received (4 per word). Words are tagged mem_is_rx = 1.
- R8: Status bit 1 is set when a receive advance changes physical address bit 11.
- R9: Writing the status register clears each stored bit written as 1 and leaves bits written as 0 unchanged.
- R10: Status reads return cfg_variant in bit 2. That bit is not stored and never raises the interrupt.
- R11: irq is high exactly when a stored status bit and the matching mask bit are both 1. The mask register reads back all 32 written bits.
- R12: After reset every register reads zero (status bit 2 reflects the strap), irq is low and no request is issued. The counter slot at 0x50 always reads zero.
- R13: When one control write enables both directions, the full transmit transfer runs before the receive transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| cfg_variant | input | 1 | Static board-variant strap |
| mem_valid | output | 1 | Word request valid |
| mem_ready | input | 1 | Word request accepted |
| mem_addr | output | 34 | Physical byte address of the word |
| mem_is_rx | output | 1 | 1 = receive word, 0 = transmit word |
| mem_last | input | 1 | Receive source ends the transfer with this word |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults show up at the ports within one transfer. A wrong word count or a wrong page boundary appears as the number and addresses of accepted handshakes, and as the pointer value read back on the first read after mem_valid drops. A wrong half-page or page-end decision appears in the status readback and in irq one cycle after the final handshake. Errors in mask or clear logic appear on irq in the cycle after the register write.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int PA_W  = 34;
  localparam int REG_W = 32;

  localparam int SLOT_CTRL = 0;
  localparam int SLOT_TXP  = 1;
  localparam int SLOT_RXP  = 2;
  localparam int SLOT_ISR  = 3;
  localparam int SLOT_IMR  = 4;
  localparam int N_SLOTS   = 5;

  localparam int CTRL_TX   = 0;
  localparam int CTRL_RX   = 1;
  localparam int ST_TXEND  = 0;
  localparam int ST_RXHALF = 1;

  typedef enum logic [1:0] {ENG_IDLE, ENG_TX, ENG_RX} eng_st_e;

  // rotated pointer form: high five address bits live in the low register bits
  function automatic logic [PA_W-1:0] ptr_decode(input logic [REG_W-1:0] r);
    return {r[4:0], r[31:5], 2'b00};
  endfunction

  function automatic logic [REG_W-1:0] ptr_encode(input logic [PA_W-1:0] a);
    return {a[28:2], a[33:29]};
  endfunction
endpackage

// File: rtl/sdma_bus_decode.sv
module sdma_bus_decode #(
  parameter int ADDR_W  = 8,
  parameter int N_SLOTS = 5
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  output logic [N_SLOTS-1:0] rd_hit,
  output logic [N_SLOTS-1:0] wr_hit
);
  localparam int SLOT_W = ADDR_W - 4;

  logic              aligned;
  logic [SLOT_W-1:0] slot;

  assign aligned = (bus_addr[3:0] == 4'h0);
  assign slot    = bus_addr[ADDR_W-1:4];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign rd_hit[i] = aligned && (slot == SLOT_W'(i));
    assign wr_hit[i] = rd_hit[i] && bus_we;
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_tx,
  input  logic                 start_rx,
  input  logic [PA_W-1:0]      tx_base,
  input  logic [PA_W-1:0]      rx_base,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  input  logic                 mem_last,
  output logic [PA_W-1:0]      mem_addr,
  output logic                 mem_is_rx,
  output logic                 tx_done,
  output logic                 rx_done,
  output logic [PAGE_BITS:0]   rx_bytes,
  output logic                 busy
);
  localparam int WCNT_W     = PAGE_BITS - 1;
  localparam int PAGE_WORDS = 1 << (PAGE_BITS - 2);

  eng_st_e           st_q, st_d;
  logic [PA_W-1:0]   cur_q, cur_d;
  logic [WCNT_W-1:0] left_q, left_d;
  logic [WCNT_W-1:0] moved_q, moved_d;
  logic              pend_q, pend_d;
  logic              hs, eng_en;

  function automatic logic [WCNT_W-1:0] words_to_end(input logic [PA_W-1:0] a);
    return WCNT_W'(PAGE_WORDS) - {1'b0, a[PAGE_BITS-1:2]};
  endfunction

  assign busy      = (st_q != ENG_IDLE);
  assign mem_valid = busy;
  assign mem_addr  = cur_q;
  assign mem_is_rx = (st_q == ENG_RX);
  assign hs        = mem_valid && mem_ready;
  assign rx_bytes  = {moved_q + WCNT_W'(1), 2'b00};
  assign eng_en    = busy || start;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    left_d  = left_q;
    moved_d = moved_q;
    pend_d  = pend_q;
    tx_done = 1'b0;
    rx_done = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          moved_d = '0;
          pend_d  = start_rx;
          if (start_tx) begin
            st_d   = ENG_TX;
            cur_d  = tx_base;
            left_d = words_to_end(tx_base);
          end else if (start_rx) begin
            st_d   = ENG_RX;
            cur_d  = rx_base;
            left_d = words_to_end(rx_base);
            pend_d = 1'b0;
          end
        end
      end
      ENG_TX: begin
        if (hs) begin
          cur_d  = cur_q + PA_W'(4);
          left_d = left_q - WCNT_W'(1);
          if (left_q == WCNT_W'(1)) begin
            tx_done = 1'b1;
            if (pend_q) begin
              st_d    = ENG_RX;
              cur_d   = rx_base;
              left_d  = words_to_end(rx_base);
              moved_d = '0;
              pend_d  = 1'b0;
            end else begin
              st_d = ENG_IDLE;
            end
          end
        end
      end
      ENG_RX: begin
        if (hs) begin
          cur_d   = cur_q + PA_W'(4);
          left_d  = left_q - WCNT_W'(1);
          moved_d = moved_q + WCNT_W'(1);
          if ((left_q == WCNT_W'(1)) || mem_last) begin
            rx_done = 1'b1;
            st_d    = ENG_IDLE;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      moved_q <= '0;
      pend_q  <= 1'b0;
    end else if (eng_en) begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      left_q  <= left_d;
      moved_q <= moved_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/sdma_page_ctrl.sv
module sdma_page_ctrl
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cfg_variant,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [33:0]       mem_addr,
  output logic              mem_is_rx,
  input  logic              mem_last,
  output logic              irq
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_SLOTS-1:0] rd_hit, wr_hit;

  logic [1:0]       ctrl_q, ctrl_d;
  logic [REG_W-1:0] ptr_tx_q, ptr_tx_d, ptr_rx_q, ptr_rx_d;
  logic [1:0]       isr_q, isr_d;
  logic [REG_W-1:0] imr_q;
  logic             ctrl_en, ptx_en, prx_en, isr_en, imr_en;

  logic [PA_W-1:0]    tx_dec, rx_dec, tx_next, rx_next;
  logic               start, start_tx, start_rx;
  logic               tx_done, rx_done, busy;
  logic [PAGE_BITS:0] rx_bytes;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdma_bus_decode #(.ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit)
  );

  assign tx_dec   = ptr_decode(ptr_tx_q);
  assign rx_dec   = ptr_decode(ptr_rx_q);
  assign start    = wr_hit[SLOT_CTRL] && !busy;
  assign start_tx = bus_wdata[CTRL_TX] && (tx_dec[PAGE_BITS-1:0] != '0);
  assign start_rx = bus_wdata[CTRL_RX];

  sdma_engine #(.PAGE_BITS(PAGE_BITS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .start_tx  (start_tx),
    .start_rx  (start_rx),
    .tx_base   (tx_dec),
    .rx_base   (rx_dec),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_last  (mem_last),
    .mem_addr  (mem_addr),
    .mem_is_rx (mem_is_rx),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .rx_bytes  (rx_bytes),
    .busy      (busy)
  );

  assign tx_next = {tx_dec[PA_W-1:PAGE_BITS] + 1'b1, {PAGE_BITS{1'b0}}};
  assign rx_next = rx_dec + PA_W'(rx_bytes);

  assign ctrl_en = wr_hit[SLOT_CTRL] || tx_done;
  assign ptx_en  = wr_hit[SLOT_TXP] || tx_done;
  assign prx_en  = wr_hit[SLOT_RXP] || rx_done;
  assign isr_en  = wr_hit[SLOT_CTRL] || wr_hit[SLOT_ISR] || tx_done || rx_done;
  assign imr_en  = wr_hit[SLOT_IMR];

  always_comb begin
    ctrl_d   = ctrl_q;
    ptr_tx_d = ptr_tx_q;
    ptr_rx_d = ptr_rx_q;
    isr_d    = isr_q;
    if (wr_hit[SLOT_CTRL]) begin
      ctrl_d          = bus_wdata[1:0];
      isr_d[ST_TXEND] = 1'b0;
    end
    if (wr_hit[SLOT_TXP]) ptr_tx_d = bus_wdata;
    if (wr_hit[SLOT_RXP]) ptr_rx_d = bus_wdata;
    if (wr_hit[SLOT_ISR]) isr_d = isr_d & ~bus_wdata[1:0];
    if (tx_done) begin
      isr_d[ST_TXEND] = 1'b1;
      ctrl_d[CTRL_TX] = 1'b0;
      ptr_tx_d        = ptr_encode(tx_next);
    end
    if (rx_done) begin
      ptr_rx_d = ptr_encode(rx_next);
      if (rx_next[PAGE_BITS-1] != rx_dec[PAGE_BITS-1]) isr_d[ST_RXHALF] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q   <= '0;
      ptr_tx_q <= '0;
      ptr_rx_q <= '0;
      isr_q    <= '0;
      imr_q    <= '0;
    end else begin
      if (ctrl_en) ctrl_q   <= ctrl_d;
      if (ptx_en)  ptr_tx_q <= ptr_tx_d;
      if (prx_en)  ptr_rx_q <= ptr_rx_d;
      if (isr_en)  isr_q    <= isr_d;
      if (imr_en)  imr_q    <= bus_wdata;
    end
  end

  assign irq = |(isr_q & imr_q[1:0]);

  always_comb begin
    bus_rdata = '0;
    if (rd_hit[SLOT_CTRL]) bus_rdata = {30'b0, ctrl_q};
    if (rd_hit[SLOT_TXP])  bus_rdata = ptr_tx_q;
    if (rd_hit[SLOT_RXP])  bus_rdata = ptr_rx_q;
    if (rd_hit[SLOT_ISR])  bus_rdata = {29'b0, cfg_variant, isr_q};
    if (rd_hit[SLOT_IMR])  bus_rdata = imr_q;
  end
endmodule

// File: rtl/sdma_page_ctrl_chk.sv
module sdma_page_ctrl_chk
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [33:0]       mem_addr,
  input logic              mem_is_rx,
  input logic              irq,
  input logic [1:0]        ctrl_q,
  input logic [1:0]        isr_q,
  input logic [31:0]       imr_q,
  input logic [31:0]       ptr_tx_q,
  input logic              rx_done,
  input logic              busy
);
  logic [PA_W-1:0] txd;
  logic            misaligned, ctrl_wr, isr_wr;

  assign txd        = ptr_decode(ptr_tx_q);
  assign misaligned = bus_we && (bus_addr[3:0] != 4'h0);
  assign ctrl_wr    = bus_we && (bus_addr == ADDR_W'(SLOT_CTRL * 16));
  assign isr_wr     = bus_we && (bus_addr == ADDR_W'(SLOT_ISR * 16));

  AST_MISALIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    misaligned |=> $stable(imr_q)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_is_rx))); // R3

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_is_rx != $past(mem_is_rx)) ||
      (mem_addr[PA_W-1:PAGE_BITS] == $past(mem_addr[PA_W-1:PAGE_BITS])))); // R3

  AST_ZERO_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_wr && !busy && bus_wdata[CTRL_TX] && !bus_wdata[CTRL_RX] &&
     (txd[PAGE_BITS-1:0] == '0)) |=> !mem_valid); // R4

  AST_PAGE_END_DISABLES: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(isr_q[ST_TXEND]) |-> !ctrl_q[CTRL_TX]); // R5

  AST_W1C_RXHALF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (isr_wr && bus_wdata[ST_RXHALF] && !rx_done) |=> !isr_q[ST_RXHALF]); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (imr_q[1:0] == 2'b00) |-> !irq); // R11
endmodule

bind sdma_page_ctrl sdma_page_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_is_rx (mem_is_rx),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .isr_q     (isr_q),
  .imr_q     (imr_q),
  .ptr_tx_q  (ptr_tx_q),
  .rx_done   (rx_done),
  .busy      (busy)
);

// File: tb/tb_sdma_page_ctrl.sv
module tb_sdma_page_ctrl;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_TXP = 8'h10, A_RXP = 8'h20,
                         A_ISR = 8'h30, A_IMR = 8'h40, A_TICK = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cfg_variant;
  logic        mem_valid, mem_ready, mem_is_rx, mem_last, irq;
  logic [33:0] mem_addr;

  int checks = 0;
  int errors = 0;

  // memory-side model state
  int          rdy_mode = 0;
  int          stop_after = 0;
  int          rx_mark = 0;
  int          word_mark = 0;
  int          n_words = 0, n_tx = 0, n_rx = 0;
  logic        hs_pend = 1'b0;
  logic [33:0] pend_addr;
  logic        pend_rx;
  logic [33:0] first_addr;
  logic        first_rx, last_rx;

  always #2 clk = ~clk;

  sdma_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(12)) dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .cfg_variant (cfg_variant),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_addr (mem_addr),
    .mem_is_rx (mem_is_rx), .mem_last (mem_last), .irq (irq)
  );

  always @(negedge clk) begin
    if (hs_pend) begin
      if (n_words == word_mark) begin
        first_addr = pend_addr;
        first_rx   = pend_rx;
      end
      last_rx = pend_rx;
      n_words = n_words + 1;
      if (pend_rx) n_rx = n_rx + 1;
      else         n_tx = n_tx + 1;
    end
    mem_ready = (rdy_mode == 0) ? 1'b1 : ~mem_ready;
    mem_last  = (stop_after != 0) && ((n_rx - rx_mark) == stop_after - 1);
    hs_pend   = mem_valid && mem_ready;
    pend_addr = mem_addr;
    pend_rx   = mem_is_rx;
  end

  function automatic logic [31:0] enc(input logic [63:0] a);
    logic [63:0] v;
    v = ((a << 3) & ~64'h1f) | ((a >> 29) & 64'h1f);
    return v[31:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      if (!mem_valid) break;
    end
  endtask

  task automatic mark();
    word_mark = n_words;
    rx_mark   = n_rx;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_CTRL, d); check("R12 ctrl reset", d, 0);
    bus_read(A_TXP, d);  check("R12 txp reset", d, 0);
    bus_read(A_RXP, d);  check("R12 rxp reset", d, 0);
    bus_read(A_ISR, d);  check("R12 isr reset", d, 0);
    bus_read(A_IMR, d);  check("R12 imr reset", d, 0);
    bus_read(A_TICK, d); check("R12 counter reads zero", d, 0);
    check("R12 irq reset", irq, 0);
    check("R12 no request", mem_valid, 0);
  endtask

  task automatic t_tx_page();
    logic [31:0] d;
    int tx0;
    rdy_mode = 1; stop_after = 0; mark(); tx0 = n_tx;
    bus_write(A_TXP, enc(64'h2_1234_5FF0));
    bus_read(A_TXP, d); check("R2 pointer readback", d, enc(64'h2_1234_5FF0));
    bus_write(A_CTRL, 32'h1);
    wait_idle();
    check("R2 first address decoded", first_addr, 34'h2_1234_5FF0);
    check("R3 tx tag", first_rx, 0);
    check("R3 tx word count", n_tx - tx0, 4);
    bus_read(A_CTRL, d); check("R5 tx enable cleared", d, 0);
    bus_read(A_ISR, d);  check("R5 page-end set", d, 1);
    bus_read(A_TXP, d);  check("R5 pointer next page", d, enc(64'h2_1234_6000));
    check("R11 irq masked off", irq, 0);
    rdy_mode = 0;
  endtask

  task automatic t_ctrl_clears();
    logic [31:0] d;
    bus_write(A_CTRL, 32'h0);
    bus_read(A_ISR, d); check("R6 ctrl write clears page-end", d, 0);
  endtask

  task automatic t_tx_zero_offset();
    logic [31:0] d;
    int tx0;
    tx0 = n_tx;
    bus_write(A_TXP, enc(64'h1_0000_3000));
    bus_write(A_CTRL, 32'h1);
    repeat (30) @(negedge clk);
    check("R4 no transfer", n_tx - tx0, 0);
    bus_read(A_ISR, d);  check("R4 no event", d, 0);
    bus_read(A_CTRL, d); check("R4 enable kept", d, 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_rx_early_half();
    logic [31:0] d;
    int rx0;
    stop_after = 3; mark(); rx0 = n_rx;
    bus_write(A_RXP, enc(64'h0_8000_17F8));
    bus_write(A_CTRL, 32'h2);
    wait_idle();
    check("R7 rx words until last", n_rx - rx0, 3);
    check("R7 rx tag", first_rx, 1);
    check("R2 rx first address", first_addr, 34'h0_8000_17F8);
    bus_read(A_RXP, d);  check("R7 rx pointer advanced", d, enc(64'h0_8000_1804));
    bus_read(A_CTRL, d); check("R7 rx enable kept", d, 2);
    bus_read(A_ISR, d);  check("R8 half-page set on bit 11 change", d, 2);
    stop_after = 0;
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(A_TXP, enc(64'h3_FFFF_FFF8));
    bus_write(A_CTRL, 32'h1);
    wait_idle();
    bus_read(A_TXP, d); check("R5 pointer wraps at 34 bits", d, enc(64'h0));
    bus_read(A_ISR, d); check("R9 both set", d, 3);
    bus_write(A_ISR, 32'h1);
    bus_read(A_ISR, d); check("R9 clear only bit 0", d, 2);
    bus_write(A_ISR, 32'h0);
    bus_read(A_ISR, d); check("R9 zero write keeps bits", d, 2);
    bus_write(A_ISR, 32'h2);
    bus_read(A_ISR, d); check("R9 clear bit 1", d, 0);
  endtask

  task automatic t_rx_no_half();
    logic [31:0] d;
    stop_after = 2; mark();
    bus_write(A_RXP, enc(64'h1_2345_6100));
    bus_write(A_CTRL, 32'h2);
    wait_idle();
    bus_read(A_RXP, d); check("R7 rx pointer plus 8", d, enc(64'h1_2345_6108));
    bus_read(A_ISR, d); check("R8 no half-page inside a half", d, 0);
    stop_after = 0;
  endtask

  task automatic t_rx_page_end();
    logic [31:0] d;
    int rx0;
    mark(); rx0 = n_rx;
    bus_write(A_RXP, enc(64'h0_0000_0FF8));
    bus_write(A_CTRL, 32'h2);
    wait_idle();
    check("R7 rx stops at page end", n_rx - rx0, 2);
    bus_read(A_RXP, d); check("R7 rx pointer next page", d, enc(64'h0_0000_1000));
    bus_read(A_ISR, d); check("R8 half-page on page wrap", d, 2);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(A_IMR, 32'h1);
    check("R11 unmatched mask", irq, 0);
    bus_write(A_IMR, 32'h2);
    check("R11 matched mask", irq, 1);
    bus_write(A_IMR, 32'hFFFF_FFFF);
    bus_read(A_IMR, d); check("R11 mask readback", d, 32'hFFFF_FFFF);
    bus_write(A_ISR, 32'h2);
    check("R11 irq drops after clear", irq, 0);
    cfg_variant = 1'b1;
    #1;
    check("R10 strap raises no irq", irq, 0);
    bus_read(A_ISR, d); check("R10 strap in bit 2", d, 4);
    cfg_variant = 1'b0;
    bus_write(A_IMR, 32'h0);
  endtask

  task automatic t_misaligned();
    logic [31:0] d;
    bus_write(A_TXP, 32'hA5A5_0000);
    bus_write(8'h11, 32'h1234_5678);
    bus_read(A_TXP, d); check("R1 misaligned write ignored", d, 32'hA5A5_0000);
    bus_read(8'h11, d); check("R1 misaligned read zero", d, 0);
    bus_write(8'h42, 32'hFFFF_FFFF);
    bus_read(A_IMR, d); check("R1 mask untouched", d, 0);
    bus_write(A_TICK, 32'hFFFF_FFFF);
    bus_read(A_TICK, d); check("R12 counter still zero", d, 0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    int tx0, rx0;
    mark(); tx0 = n_tx; rx0 = n_rx;
    bus_write(A_TXP, enc(64'h0_0000_1FF8));
    bus_write(A_RXP, enc(64'h0_0000_2FF0));
    bus_write(A_CTRL, 32'h3);
    wait_idle();
    check("R13 transmit first", first_rx, 0);
    check("R13 receive last", last_rx, 1);
    check("R13 tx words", n_tx - tx0, 2);
    check("R13 rx words", n_rx - rx0, 4);
    bus_read(A_ISR, d);  check("R13 both events", d, 3);
    bus_read(A_CTRL, d); check("R13 ctrl after both", d, 2);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    cfg_variant = 1'b0; mem_ready = 1'b0; mem_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_page();
    t_ctrl_clears();
    t_tx_zero_offset();
    t_rx_early_half();
    t_w1c();
    t_rx_no_half();
    t_rx_page_end();
    t_mask();
    t_misaligned();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule